// File: doc/BRIEF.md
# SPI Transaction Sequencer with Receive Skip

This block runs one SPI master transaction from a single 32-bit command word. It checks the command, drives the selected chip-select line low, and clocks the requested number of bytes. Outgoing bytes come from a transmit byte stream with a valid/ready handshake. Captured bytes go to a receive byte stream as one-cycle valid strobes. When the transaction ends it releases the chip select and pulses `done` for one cycle.

An external divider sets the serial clock rate. It supplies `sckTick`, one strobe for each half period of the serial clock. The block uses SPI mode 0: the serial clock idles low and input data is sampled on its rising edge. Each chip select has its own character width and bit order, supplied as inputs. A receive-skip count lets the first bytes go out as a command phase while nothing is captured for them. After that phase the response can be received over two data lines. A loopback input routes the serial output back to the primary input line.

Top module: `spi_skip_sequencer`

## Requirements
- R1: After reset all `csN` lines are high, and `sck`, `done`, `rxValid` and `txReady` are low.
- R2: A command is accepted only in the idle state, only while `enable` is high, and only when its reserved bits (29 and 26:24) are zero. Any other command causes no serial activity and no `done`.
- R3: Command bits 31:30 select the chip select. During the transaction only that `csN` line is low.
- R4: The transaction moves (bits 15:0 + 1) bytes. After the last serial clock all `csN` lines return high, and `done` is high for exactly one cycle while they are high.
- R5: A select whose 4-bit width field is not 15 uses 8-bit characters. Its order bit set to 1 sends and receives the most significant bit first; set to 0, the least significant bit first.
- R6: A select whose width field is 15 uses 16-bit characters. The first stream byte of each character is its low half, bit order applies across all 16 bits, and received characters are pushed low half first.
- R7: A nonzero skip count in bits 23:16 means only that many bytes are pulled from the transmit stream, and no receive byte is pushed for them. The remaining bytes drive `mosi` low and pull nothing from the stream.
- R8: Dual mode (bit 28) with a nonzero skip count receives each post-skip character at two bits per clock. `misoLine1` carries the earlier bit of each pair in shift order and `misoLine0` the later. With a skip count of zero the dual bit is ignored.
- R9: Transmit-only mode (bit 27) pushes no receive bytes. Transmit data is still sent.
- R10: While a transmit byte is needed and `txValid` is low, `sck` stays low and no bit is shifted.
- R11: With `loopEn` high, the primary input line is replaced by the block's own `mosi`.
- R12: `sck` is high only while a chip select is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Global enable; gates command acceptance |
| loopEn | input | 1 | Internal loopback of `mosi` to the input line |
| cmdValid | input | 1 | Command strobe |
| cmdWord | input | 32 | Command: select, dual, transmit-only, skip, length-1 |
| charLenCfg | input | 4*NUM_CS | Per-select character width minus one (15 selects 16 bits) |
| msbFirstCfg | input | NUM_CS | Per-select bit order, 1 = MSB first |
| sckTick | input | 1 | Half-period strobe from the clock divider |
| txData | input | 8 | Transmit stream byte |
| txValid | input | 1 | Transmit byte available |
| txReady | output | 1 | Sequencer wants a transmit byte |
| rxData | output | 8 | Received byte |
| rxValid | output | 1 | Received byte strobe |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| misoLine0 | input | 1 | Primary serial data in |
| misoLine1 | input | 1 | Second data line used in dual phase |
| csN | output | NUM_CS | Active-low chip selects |
| done | output | 1 | One-cycle end-of-transaction pulse |

## Verification
On every cycle, the embedded assertions check that at most one chip select is low, that the serial clock never runs without a select, and that `done` is a single-cycle pulse seen with all selects released. They also check that no receive byte is produced in transmit-only mode or inside the skip phase, and that the sequencer holds while transmit data is missing. Only the bench scenarios show that the serial bit order is right for each width and order setting. The same holds for the placement of bits on the two lines in dual phase, the exact count of clock edges and pulled bytes, and the loopback data path. The bench predicts these from the requirements and compares them edge by edge.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  // command word layout (fixed by the word format)
  localparam int CMD_W      = 32;
  localparam int CS_LSB     = 30;
  localparam int CS_W       = 2;
  localparam int RSV_HI_BIT = 29;
  localparam int DUAL_BIT   = 28;
  localparam int TXONLY_BIT = 27;
  localparam int RSV_MSB    = 26;
  localparam int SKIP_LSB   = 16;
  localparam int SKIP_W     = 8;
  localparam int LEN_W      = 16;
  localparam int CNT_W      = LEN_W + 1;
  localparam int CFG_W      = 4;
  localparam int BYTE_W     = 8;
  localparam int CHAR_MAX   = 2 * BYTE_W;
  localparam int BIT_W      = $clog2(CHAR_MAX) + 1;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_LOW, S_HIGH, S_PUSH, S_FINISH
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic                       clrChar;
    logic                       loadLo;
    logic                       loadHi;
    logic                       sample;
    logic                       dual;
    logic                       drive;
    logic                       selHi;
    logic                       msbFirst;
    logic                       wide;
    logic [$clog2(CHAR_MAX)-1:0] bitIdx;
  } seqStrobe_t;
endpackage

// File: rtl/spi_seq_datapath.sv
module spi_seq_datapath
  import spi_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        ctl,
  input  logic              loopEn,
  input  logic [BYTE_W-1:0] txByte,
  input  logic              misoLine0,
  input  logic              misoLine1,
  output logic              mosi,
  output logic [BYTE_W-1:0] rxByte
);
  localparam int IDX_W = $clog2(CHAR_MAX);

  logic [CHAR_MAX-1:0] txChar;
  logic [CHAR_MAX-1:0] rxChar;
  logic [IDX_W-1:0]    pos0;
  logic [IDX_W-1:0]    pos1;
  logic [IDX_W-1:0]    topIdx;
  logic [IDX_W-1:0]    nextIdx;
  logic                line0;

  always_comb begin
    topIdx  = ctl.wide ? IDX_W'(CHAR_MAX - 1) : IDX_W'(BYTE_W - 1);
    nextIdx = ctl.bitIdx + IDX_W'(1);
    pos0    = ctl.msbFirst ? (topIdx - ctl.bitIdx) : ctl.bitIdx;
    pos1    = ctl.msbFirst ? (topIdx - nextIdx)    : nextIdx;
    mosi    = ctl.drive ? txChar[pos0] : 1'b0;
    line0   = loopEn ? mosi : misoLine0;
    rxByte  = ctl.selHi ? rxChar[CHAR_MAX-1:BYTE_W] : rxChar[BYTE_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txChar <= '0;
      rxChar <= '0;
    end else begin
      if (ctl.clrChar) begin
        txChar <= '0;
        rxChar <= '0;
      end
      if (ctl.loadLo) txChar[BYTE_W-1:0]        <= txByte;
      if (ctl.loadHi) txChar[CHAR_MAX-1:BYTE_W] <= txByte;
      if (ctl.sample) begin
        if (ctl.dual) begin
          rxChar[pos0] <= misoLine1;
          rxChar[pos1] <= misoLine0;
        end else begin
          rxChar[pos0] <= line0;
        end
      end
    end
  end

  // loading a character and shifting it never overlap
  p_load_sample_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadLo || ctl.loadHi) |-> !ctl.sample);
endmodule

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_seq_pkg::*;
#(
  parameter int NUM_CS = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    enable,
  input  logic                    cmdValid,
  input  logic [CMD_W-1:0]        cmdWord,
  input  logic [NUM_CS*CFG_W-1:0] charLenCfg,
  input  logic [NUM_CS-1:0]       msbFirstCfg,
  input  logic                    sckTick,
  input  logic                    txValid,
  output logic                    txReady,
  output logic                    rxValid,
  output logic                    sck,
  output logic [NUM_CS-1:0]       csN,
  output logic                    done,
  output seqStrobe_t              ctl
);
  seqState_t         state;
  logic [CS_W-1:0]   csIdx;
  logic [LEN_W-1:0]  lenM1;
  logic [SKIP_W-1:0] skipQ;
  logic              dualQ, txOnlyQ, wideQ, msbQ;
  logic [CNT_W-1:0]  charStart;
  logic              byteSel;
  logic [BIT_W-1:0]  bitIdx;

  logic [CS_W-1:0]   cmdCs;
  logic              cmdOk, start;
  logic [CNT_W-1:0]  curByte, skipExt, bpc;
  logic              needTx, inRx, dualNow, lastBit, lastChar;
  logic              pushNeeded, fetchAdv, endChar, goNext, csActive;
  logic [BIT_W-1:0]  step, charBits;

  always_comb begin
    cmdCs    = cmdWord[CS_LSB +: CS_W];
    cmdOk    = cmdValid && enable && !cmdWord[RSV_HI_BIT]
               && (cmdWord[RSV_MSB:SKIP_LSB+SKIP_W] == '0)
               && (int'(cmdCs) < NUM_CS);
    start    = (state == S_IDLE) && cmdOk;
    curByte  = charStart + CNT_W'(byteSel);
    skipExt  = CNT_W'(skipQ);
    needTx   = (skipQ == '0) || (curByte < skipExt);
    inRx     = charStart >= skipExt;
    dualNow  = dualQ && (skipQ != '0) && inRx;
    step     = dualNow ? BIT_W'(2) : BIT_W'(1);
    charBits = wideQ ? BIT_W'(CHAR_MAX) : BIT_W'(BYTE_W);
    lastBit  = ({1'b0, bitIdx} + {1'b0, step}) >= {1'b0, charBits};
    bpc      = wideQ ? CNT_W'(2) : CNT_W'(1);
    lastChar = (charStart + bpc) > CNT_W'(lenM1);
    pushNeeded = !txOnlyQ && inRx;
    fetchAdv = (state == S_FETCH) && (!needTx || txValid);
    endChar  = (state == S_HIGH) && sckTick && lastBit;
    goNext   = (endChar && !pushNeeded)
               || ((state == S_PUSH) && !(wideQ && !byteSel));
    csActive = (state == S_FETCH) || (state == S_LOW)
               || (state == S_HIGH) || (state == S_PUSH);

    txReady  = (state == S_FETCH) && needTx;
    rxValid  = (state == S_PUSH);
    sck      = (state == S_HIGH);
    done     = (state == S_FINISH);

    ctl.clrChar  = start || (goNext && !lastChar);
    ctl.loadLo   = txReady && txValid && !byteSel;
    ctl.loadHi   = txReady && txValid && byteSel;
    ctl.sample   = (state == S_LOW) && sckTick;
    ctl.dual     = dualNow;
    ctl.drive    = (state == S_LOW) || (state == S_HIGH);
    ctl.selHi    = byteSel;
    ctl.msbFirst = msbQ;
    ctl.wide     = wideQ;
    ctl.bitIdx   = bitIdx[BIT_W-2:0];
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign csN[g] = !(csActive && (int'(csIdx) == g));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      csIdx     <= '0;
      lenM1     <= '0;
      skipQ     <= '0;
      dualQ     <= 1'b0;
      txOnlyQ   <= 1'b0;
      wideQ     <= 1'b0;
      msbQ      <= 1'b0;
      charStart <= '0;
      byteSel   <= 1'b0;
      bitIdx    <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          csIdx     <= cmdCs;
          lenM1     <= cmdWord[LEN_W-1:0];
          skipQ     <= cmdWord[SKIP_LSB +: SKIP_W];
          dualQ     <= cmdWord[DUAL_BIT];
          txOnlyQ   <= cmdWord[TXONLY_BIT];
          wideQ     <= charLenCfg[{cmdCs, 2'b00} +: CFG_W] == {CFG_W{1'b1}};
          msbQ      <= msbFirstCfg[cmdCs];
          charStart <= '0;
          byteSel   <= 1'b0;
          state     <= S_FETCH;
        end
        S_FETCH: if (fetchAdv) begin
          if (wideQ && !byteSel) byteSel <= 1'b1;
          else begin
            byteSel <= 1'b0;
            bitIdx  <= '0;
            state   <= S_LOW;
          end
        end
        S_LOW: if (sckTick) state <= S_HIGH;
        S_HIGH: if (sckTick) begin
          if (!lastBit) begin
            bitIdx <= bitIdx + step;
            state  <= S_LOW;
          end else if (pushNeeded) begin
            byteSel <= 1'b0;
            state   <= S_PUSH;
          end
        end
        S_PUSH: if (wideQ && !byteSel) byteSel <= 1'b1;
        S_FINISH: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
      if (goNext) begin
        byteSel <= 1'b0;
        if (lastChar) state <= S_FINISH;
        else begin
          charStart <= charStart + bpc;
          state     <= S_FETCH;
        end
      end
    end
  end

  p_enable_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && !enable) |=> (state == S_IDLE));
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_skip_norx_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> (charStart >= skipExt));
  p_dual_skip_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.sample && ctl.dual) |-> (skipQ != '0));
  p_txonly_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> !txOnlyQ);
  p_stall_r10: assert property (@(posedge clk) disable iff (!rstN)
    (txReady && !txValid) |=> (state == S_FETCH) && !sck);
endmodule

// File: rtl/spi_skip_sequencer.sv
module spi_skip_sequencer
  import spi_seq_pkg::*;
#(
  parameter int NUM_CS = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    enable,
  input  logic                    loopEn,
  input  logic                    cmdValid,
  input  logic [CMD_W-1:0]        cmdWord,
  input  logic [NUM_CS*CFG_W-1:0] charLenCfg,
  input  logic [NUM_CS-1:0]       msbFirstCfg,
  input  logic                    sckTick,
  input  logic [BYTE_W-1:0]       txData,
  input  logic                    txValid,
  output logic                    txReady,
  output logic [BYTE_W-1:0]       rxData,
  output logic                    rxValid,
  output logic                    sck,
  output logic                    mosi,
  input  logic                    misoLine0,
  input  logic                    misoLine1,
  output logic [NUM_CS-1:0]       csN,
  output logic                    done
);
  seqStrobe_t ctl;

  spi_seq_ctrl #(.NUM_CS(NUM_CS)) i_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .cmdValid(cmdValid),
    .cmdWord(cmdWord), .charLenCfg(charLenCfg), .msbFirstCfg(msbFirstCfg),
    .sckTick(sckTick), .txValid(txValid), .txReady(txReady),
    .rxValid(rxValid), .sck(sck), .csN(csN), .done(done), .ctl(ctl)
  );

  spi_seq_datapath i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .loopEn(loopEn), .txByte(txData),
    .misoLine0(misoLine0), .misoLine1(misoLine1), .mosi(mosi),
    .rxByte(rxData)
  );

  p_cs_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));
  p_done_cs_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (&csN));
  p_sck_cs_r12: assert property (@(posedge clk) disable iff (!rstN)
    sck |-> !(&csN));
endmodule

// File: tb/test_spi_skip_sequencer.sv
`timescale 1ns/1ps
module test_spi_skip_sequencer;
  localparam int NCS = 4;
  localparam int ME = 512;

  logic clk = 0, rstN = 0, enable = 0, loopEn = 0, cmdValid = 0;
  logic [31:0] cmdWord = '0;
  logic [NCS*4-1:0] charLenCfg = '0;
  logic [NCS-1:0] msbFirstCfg = '0;
  logic sckTick = 0, txValid = 0, misoLine0 = 0, misoLine1 = 0;
  logic [7:0] txData = '0;
  logic txReady, rxValid, sck, mosi, done;
  logic [7:0] rxData;
  logic [NCS-1:0] csN;

  spi_skip_sequencer #(.NUM_CS(NCS)) i_spi_skip_sequencer (
    .clk(clk), .rstN(rstN), .enable(enable), .loopEn(loopEn),
    .cmdValid(cmdValid), .cmdWord(cmdWord), .charLenCfg(charLenCfg),
    .msbFirstCfg(msbFirstCfg), .sckTick(sckTick), .txData(txData),
    .txValid(txValid), .txReady(txReady), .rxData(rxData),
    .rxValid(rxValid), .sck(sck), .mosi(mosi), .misoLine0(misoLine0),
    .misoLine1(misoLine1), .csN(csN), .done(done)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0] txQ [64];
  logic [7:0] rxExp [64];
  logic [7:0] rxGot [64];
  logic l0 [ME];
  logic l1 [ME];
  logic mExp [ME];
  logic mGot [ME];
  int nEdge, nRxExp, txNeeded;
  int txIdx, txAvail, edgeCnt, rxCnt, doneCnt, csErr, sckNoCs, stallCyc, stallErr, doneErr;
  logic [NCS-1:0] expCs;
  bit gapEn = 0, hsPend = 0, tickPh = 0, prevSck = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // stimulus sources and monitor, away from the active edge
  always @(negedge clk) begin
    sckTick = tickPh;
    tickPh = !tickPh;
    if (hsPend) txIdx++;
    if (txIdx < txAvail && !(gapEn && ($urandom % 3 == 0))) begin
      txValid = 1; txData = txQ[txIdx];
    end else begin
      txValid = 0; txData = 8'h00;
    end
    hsPend = txValid && txReady;
    if (txReady && !txValid) stallCyc++;
    if (txReady && !txValid && sck) stallErr++;
    if (sck && !prevSck) begin
      if (edgeCnt < ME) mGot[edgeCnt] = mosi;
      if (csN != expCs) csErr++;
      edgeCnt++;
    end
    prevSck = sck;
    if (sck && (&csN)) sckNoCs++;
    misoLine0 = (edgeCnt < ME) ? l0[edgeCnt] : 1'b0;
    misoLine1 = (edgeCnt < ME) ? l1[edgeCnt] : 1'b0;
    if (rxValid) begin
      if (rxCnt < 64) rxGot[rxCnt] = rxData;
      rxCnt++;
    end
    if (done) begin
      doneCnt++;
      if (!(&csN)) doneErr++;
    end
  end

  function automatic int bpos(int k, bit w16, bit msb);
    int w = w16 ? 16 : 8;
    return msb ? (w - 1 - k) : k;
  endfunction

  task automatic clearMon();
    txIdx = 0; edgeCnt = 0; rxCnt = 0; doneCnt = 0; csErr = 0; sckNoCs = 0;
    stallCyc = 0; stallErr = 0; doneErr = 0; hsPend = 0; prevSck = 0;
  endtask

  task automatic runTxn(input int cs, input int len, input int skip,
                        input bit dual, input bit txOnly, input bit loop,
                        input bit wide, input bit msb, input bit gaps,
                        input string req);
    int bpc = wide ? 2 : 1;
    int w = wide ? 16 : 8;
    int wait_n = 0;
    int mis = 0;
    logic [15:0] tc, rc;
    bit dn;
    for (int i = 0; i < 64; i++) txQ[i] = 8'($urandom);
    for (int i = 0; i < ME; i++) begin l0[i] = 0; l1[i] = 0; mExp[i] = 0; end
    txNeeded = (skip != 0) ? skip : len;
    nEdge = 0; nRxExp = 0;
    for (int s = 0; s < len; s += bpc) begin
      tc = '0;
      if (s < txNeeded) tc[7:0] = txQ[s];
      if (wide && s + 1 < txNeeded) tc[15:8] = txQ[s+1];
      dn = dual && (skip != 0) && (s >= skip);
      rc = 16'($urandom);
      if (!wide) rc[15:8] = 0;
      if (loop) rc = tc;
      if (dn) begin
        for (int k = 0; k < w; k += 2) begin
          mExp[nEdge] = 0;
          l1[nEdge] = rc[bpos(k, wide, msb)];
          l0[nEdge] = rc[bpos(k + 1, wide, msb)];
          nEdge++;
        end
      end else begin
        for (int k = 0; k < w; k++) begin
          mExp[nEdge] = tc[bpos(k, wide, msb)];
          l0[nEdge] = loop ? !tc[bpos(k, wide, msb)] : rc[bpos(k, wide, msb)];
          nEdge++;
        end
      end
      if (!txOnly && s >= skip) begin
        rxExp[nRxExp] = rc[7:0]; nRxExp++;
        if (wide) begin rxExp[nRxExp] = rc[15:8]; nRxExp++; end
      end
    end
    for (int c = 0; c < NCS; c++) begin
      charLenCfg[c*4 +: 4] = (c == cs) ? (wide ? 4'hF : 4'h7) : (wide ? 4'h7 : 4'hF);
      msbFirstCfg[c] = (c == cs) ? msb : !msb;
    end
    loopEn = loop;
    gapEn = gaps;
    expCs = ~(NCS'(1) << cs);
    @(negedge clk);
    clearMon();
    txAvail = txNeeded;
    cmdWord = {2'(cs), 1'b0, dual, txOnly, 3'b000, 8'(skip), 16'(len - 1)};
    cmdValid = 1;
    @(negedge clk);
    cmdValid = 0;
    while (doneCnt == 0 && wait_n < 30000) begin @(negedge clk); wait_n++; end
    repeat (3) @(negedge clk);
    chk(doneCnt == 1, "R4", "done pulses", doneCnt, 1);
    chk(doneErr == 0, "R4", "done with select low", doneErr, 0);
    chk(edgeCnt == nEdge, req, "clock edges", edgeCnt, nEdge);
    for (int i = 0; i < nEdge && i < ME; i++) if (mGot[i] !== mExp[i]) mis++;
    chk(mis == 0, req, "mosi bit mismatches", mis, 0);
    chk(txIdx == txNeeded, req, "bytes pulled", txIdx, txNeeded);
    chk(rxCnt == nRxExp, req, "bytes pushed", rxCnt, nRxExp);
    mis = 0;
    for (int i = 0; i < nRxExp && i < rxCnt; i++) if (rxGot[i] !== rxExp[i]) mis++;
    chk(mis == 0, req, "rx byte mismatches", mis, 0);
    chk(csErr == 0, "R3", "wrong select pattern", csErr, 0);
    chk(sckNoCs == 0 && (&csN), "R12", "clock without select", sckNoCs, 0);
    chk(stallErr == 0, "R10", "clock during stall", stallErr, 0);
    gapEn = 0;
    txAvail = 0;
    loopEn = 0;
  endtask

  task automatic noStart(input logic [31:0] w, input string what);
    @(negedge clk);
    clearMon();
    cmdWord = w; cmdValid = 1;
    @(negedge clk);
    cmdValid = 0;
    repeat (30) @(negedge clk);
    chk(edgeCnt == 0 && doneCnt == 0 && (&csN), "R2", what, edgeCnt + doneCnt, 0);
  endtask

  initial begin
    int len, skip, cs;
    bit wide, msb, dual, txo, gp;
    void'($urandom(32'd4711));
    clearMon();
    txAvail = 0;
    expCs = '1;
    repeat (4) @(negedge clk);
    chk(csN == '1 && !sck && !done && !rxValid && !txReady, "R1", "reset outputs",
        int'({csN, sck, done, rxValid, txReady}), int'({4'hF, 4'h0}));
    rstN = 1;
    repeat (2) @(negedge clk);
    chk(csN == '1 && !sck && !done && !rxValid && !txReady, "R1", "idle after reset",
        int'({csN, sck, done, rxValid, txReady}), int'({4'hF, 4'h0}));
    noStart(32'h0000_0003, "command while disabled");
    enable = 1;
    noStart(32'h2000_0003, "reserved bit 29 set");
    noStart(32'h0100_0003, "reserved bit 24 set");
    runTxn(2, 4, 0, 0, 0, 0, 0, 1, 0, "R5");
    runTxn(1, 3, 0, 0, 0, 0, 0, 0, 0, "R5");
    runTxn(3, 6, 0, 0, 0, 0, 1, 1, 0, "R6");
    runTxn(0, 4, 0, 0, 0, 0, 1, 0, 0, "R6");
    runTxn(0, 8, 3, 0, 0, 0, 0, 1, 0, "R7");
    runTxn(1, 6, 2, 1, 0, 0, 0, 1, 0, "R8");
    runTxn(2, 8, 2, 1, 0, 0, 1, 0, 0, "R8");
    runTxn(3, 3, 0, 1, 0, 0, 0, 1, 0, "R8");
    runTxn(0, 5, 0, 0, 1, 0, 0, 1, 0, "R9");
    runTxn(1, 10, 0, 0, 0, 0, 0, 1, 1, "R10");
    chk(stallCyc > 0, "R10", "stall cycles exercised", stallCyc, 1);
    runTxn(2, 4, 0, 0, 0, 1, 0, 1, 0, "R11");
    runTxn(3, 1, 0, 0, 0, 0, 0, 0, 0, "R4");
    for (int t = 0; t < 30; t++) begin
      wide = 1'($urandom); msb = 1'($urandom); cs = $urandom % 4;
      len = wide ? 2 * (1 + $urandom % 12) : 1 + $urandom % 24;
      skip = 0;
      if ($urandom % 2 == 1) skip = wide ? 2 * ($urandom % (len / 2)) : $urandom % len;
      dual = (skip != 0) ? 1'($urandom) : 1'b0;
      txo = ($urandom % 4 == 0);
      gp = 1'($urandom);
      runTxn(cs, len, skip, dual, txo, 0, wide, msb, gp, "R4");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule